// File: doc/BRIEF.md
# External Bus Sizing Controller

This block connects one internal bus master to a 16-bit external data bus that is shared by eight address areas. A request from the master carries a byte, word or longword together with a 24-bit address. The top three address bits pick the area. A configuration bit for each area says whether the area's devices are 8 bits or 16 bits wide. The block splits the request into as many external cycles as that width needs. For each cycle it picks the byte lane, drives the address and the write strobes, and drives the chip select of the area. It then acknowledges the master once, after the last cycle.

Every external cycle takes three clocks. The address is on the bus from the first clock. The chip select and the read or write strobe are active in the second and third clocks, so the chip select goes inactive between the cycles of a split request. Data is big-endian: the lowest address holds the most significant byte, and split cycles run from the lowest address upward. Read data from all the cycles of a request is collected in a holding register. The result is presented right-justified and zero-extended, together with the done pulse.

Top module: `ext_bus_sizer`

## Requirements
- R1: While reset is held, all chip selects and strobes are inactive (high), done is low and rdata is zero.
- R2: Address bits 23:21 of the request select one of eight areas. Only that area's active-low chip select goes low, and no more than one chip select is ever low.
- R3: Each external cycle lasts three clocks. The address is driven from the first clock and stays stable for the whole cycle. The chip select and the strobe are low only in the second and third clocks, so the chip select is high for at least one clock between successive cycles.
- R4: In an area whose configuration bit is 1 (8-bit), a byte, word or longword request takes 1, 2 or 4 cycles at consecutive ascending addresses. Every transfer uses the upper lane: write data goes out on ext_dout[15:8] with ext_wr_hi_n, and read data is taken from ext_din[15:8]. ext_wr_lo_n is never asserted.
- R5: In a 16-bit area (configuration bit 0), a byte request takes one cycle. At an even address it uses the upper lane (ext_wr_hi_n, ext_din[15:8]). At an odd address it uses the lower lane (ext_wr_lo_n, ext_din[7:0]). The other lane's strobe stays inactive.
- R6: In a 16-bit area, a word request takes one cycle on both lanes. A longword request takes two cycles, at the address and at the address plus 2.
- R7: Size codes are 0 = byte, 1 = word, 2 = longword, and 3 is handled as a longword. Request data is right-justified in req_wdata. The first cycle carries the most significant part. Read results are packed with the first byte read as the most significant, and unused upper bits are zero.
- R8: done is a one-clock pulse in the clock after the third clock of the last cycle. So a request of n cycles is acknowledged 3n+1 clocks after the clock in which it was accepted. rdata updates only when a read completes and holds its value otherwise.
- R9: For word and longword requests, address bit 0 is ignored and treated as 0.
- R10: req_valid is sampled only while the block is idle. A request raised while a transfer is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| area_is8 | input | 8 | Per-area width configuration, 1 = 8-bit area |
| req_valid | input | 1 | Request present, taken when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 word, 2 or 3 longword |
| req_addr | input | 24 | Request byte address |
| req_wdata | input | 32 | Write data, right-justified |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 32 | Packed read result |
| ext_addr | output | 24 | External address |
| ext_cs_n | output | 8 | Active-low chip select per area |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_wr_hi_n | output | 1 | Active-low write strobe, lane 15:8 |
| ext_wr_lo_n | output | 1 | Active-low write strobe, lane 7:0 |
| ext_dout | output | 16 | External write data |
| ext_din | input | 16 | External read data |

## Verification
A corrupted cycle index or last-cycle count appears at once as the wrong number of chip-select pulses. It also moves the done pulse by a multiple of three clocks. A wrong stored width or address-bit handling shows in the second clock of the first cycle, as a wrong address, lane strobe or chip select. Errors in the read packing register stay hidden until the done pulse, when rdata shows misordered or shifted bytes. The bench therefore compares rdata and the contents of its external memory model against byte sequences it computes itself.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_ALT  = 2'd3
    } xfer_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_T1   = 2'd1,
        ST_T2   = 2'd2,
        ST_T3   = 2'd3
    } bus_state_e;

    // bytes moved by a request of the given size code
    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    size_bytes = 3'd1;
            2'd1:    size_bytes = 3'd2;
            default: size_bytes = 3'd4;
        endcase
    endfunction

    // external cycles needed for a request in an area of the given width
    function automatic logic [2:0] cycle_count(input logic is8, input logic [1:0] sz);
        if (is8)
            cycle_count = size_bytes(sz);
        else if (sz == 2'd0)
            cycle_count = 3'd1;
        else
            cycle_count = size_bytes(sz) >> 1;
    endfunction

endpackage

// File: rtl/ebs_area_decode.sv
module ebs_area_decode #(
    parameter  int AREA_N    = 8,
    localparam int AREA_BITS = $clog2(AREA_N)
) (
    input  logic [AREA_BITS-1:0] area_field,
    input  logic [AREA_N-1:0]    cfg_is8,
    output logic [AREA_BITS-1:0] area,
    output logic                 is8
);
    always_comb begin
        area = area_field;
        is8  = cfg_is8[area_field];
    end
endmodule

// File: rtl/ebs_cs_gen.sv
module ebs_cs_gen #(
    parameter  int AREA_N    = 8,
    localparam int AREA_BITS = $clog2(AREA_N)
) (
    input  logic                 active,
    input  logic [AREA_BITS-1:0] area,
    output logic [AREA_N-1:0]    cs_n
);
    for (genvar g = 0; g < AREA_N; g++) begin : g_sel
        assign cs_n[g] = ~(active && (area == AREA_BITS'(g)));
    end
endmodule

// File: rtl/ebs_lane_mux.sv
module ebs_lane_mux (
    input  logic        is8,
    input  logic [1:0]  size,
    input  logic [1:0]  idx,
    input  logic        a0,
    input  logic [31:0] wdata,
    input  logic [15:0] din,
    output logic [15:0] dout,
    output logic        lane_hi,
    output logic        lane_lo,
    output logic [15:0] rpart,
    output logic        rwide
);
    import ebs_pkg::*;

    logic [1:0] byte_sel;
    logic       half_sel;

    always_comb begin
        // byte position counted from the least significant end
        byte_sel = 2'(size_bytes(size) - 3'd1 - {1'b0, idx});
        // halfword position: word -> 0, longword -> 1 then 0
        half_sel = (size == 2'd1) ? 1'b0 : ~idx[0];

        dout    = '0;
        lane_hi = 1'b0;
        lane_lo = 1'b0;
        rpart   = '0;
        rwide   = 1'b0;

        if (is8) begin
            dout    = {wdata[{byte_sel, 3'b000} +: 8], 8'h00};
            lane_hi = 1'b1;
            rpart   = {8'h00, din[15:8]};
        end else if (size == 2'd0) begin
            if (a0) begin
                dout    = {8'h00, wdata[7:0]};
                lane_lo = 1'b1;
                rpart   = {8'h00, din[7:0]};
            end else begin
                dout    = {wdata[7:0], 8'h00};
                lane_hi = 1'b1;
                rpart   = {8'h00, din[15:8]};
            end
        end else begin
            dout    = wdata[{half_sel, 4'b0000} +: 16];
            lane_hi = 1'b1;
            lane_lo = 1'b1;
            rpart   = din;
            rwide   = 1'b1;
        end
    end
endmodule

// File: rtl/ext_bus_sizer.sv
module ext_bus_sizer #(
    parameter  int ADDR_W    = 24,
    parameter  int AREA_N    = 8,
    localparam int AREA_BITS = $clog2(AREA_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AREA_N-1:0] area_is8,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              done,
    output logic [31:0]       rdata,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [AREA_N-1:0] ext_cs_n,
    output logic              ext_rd_n,
    output logic              ext_wr_hi_n,
    output logic              ext_wr_lo_n,
    output logic [15:0]       ext_dout,
    input  logic [15:0]       ext_din
);
    import ebs_pkg::*;

    typedef struct packed {
        bus_state_e             st;
        logic [ADDR_W-1:0]      addr;
        logic [AREA_BITS-1:0]   area;
        logic                   is8;
        logic                   wr;
        logic [1:0]             size;
        logic [1:0]             idx;
        logic [1:0]             last;
        logic [31:0]            wdata;
        logic [31:0]            rbuf;
        logic [31:0]            rdata;
        logic                   done;
    } regs_t;

    regs_t r_q, r_d;

    logic [AREA_BITS-1:0] new_area;
    logic                 new_is8;
    logic                 active;
    logic [15:0]          lane_dout;
    logic                 lane_hi, lane_lo;
    logic [15:0]          rpart;
    logic                 rwide;

    ebs_area_decode #(.AREA_N(AREA_N)) u_dec (
        .area_field (req_addr[ADDR_W-1 -: AREA_BITS]),
        .cfg_is8    (area_is8),
        .area       (new_area),
        .is8        (new_is8)
    );

    ebs_lane_mux u_lane (
        .is8     (r_q.is8),
        .size    (r_q.size),
        .idx     (r_q.idx),
        .a0      (r_q.addr[0]),
        .wdata   (r_q.wdata),
        .din     (ext_din),
        .dout    (lane_dout),
        .lane_hi (lane_hi),
        .lane_lo (lane_lo),
        .rpart   (rpart),
        .rwide   (rwide)
    );

    assign active = (r_q.st == ST_T2) || (r_q.st == ST_T3);

    ebs_cs_gen #(.AREA_N(AREA_N)) u_cs (
        .active (active),
        .area   (r_q.area),
        .cs_n   (ext_cs_n)
    );

    always_comb begin
        logic [1:0]  sz;
        logic [31:0] rbuf_next;
        r_d      = r_q;
        r_d.done = 1'b0;
        sz        = (req_size == 2'd3) ? 2'd2 : req_size;
        rbuf_next = rwide ? {r_q.rbuf[15:0], rpart} : {r_q.rbuf[23:0], rpart[7:0]};
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st    = ST_T1;
                    r_d.area  = new_area;
                    r_d.is8   = new_is8;
                    r_d.wr    = req_write;
                    r_d.size  = sz;
                    r_d.idx   = 2'd0;
                    r_d.last  = 2'(cycle_count(new_is8, sz) - 3'd1);
                    r_d.wdata = req_wdata;
                    r_d.rbuf  = '0;
                    r_d.addr  = (sz != 2'd0) ? {req_addr[ADDR_W-1:1], 1'b0} : req_addr;
                end
            end
            ST_T1: r_d.st = ST_T2;
            ST_T2: r_d.st = ST_T3;
            ST_T3: begin
                if (!r_q.wr)
                    r_d.rbuf = rbuf_next;
                if (r_q.idx == r_q.last) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    if (!r_q.wr)
                        r_d.rdata = rbuf_next;
                end else begin
                    r_d.st   = ST_T1;
                    r_d.idx  = r_q.idx + 2'd1;
                    r_d.addr = r_q.addr + (r_q.is8 ? ADDR_W'(1) : ADDR_W'(2));
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

    assign done        = r_q.done;
    assign rdata       = r_q.rdata;
    assign ext_addr    = r_q.addr;
    assign ext_rd_n    = ~(active && !r_q.wr);
    assign ext_wr_hi_n = ~(active && r_q.wr && lane_hi);
    assign ext_wr_lo_n = ~(active && r_q.wr && lane_lo);
    assign ext_dout    = (r_q.wr && r_q.st != ST_IDLE) ? lane_dout : 16'h0000;

    // R2: at most one area selected
    p_cs_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ext_cs_n));

    // R3: chip select released in the first clock of every cycle
    p_cs_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_T1) |-> (&ext_cs_n));

    // R3: address held through the strobe clocks
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> $stable(ext_addr));

    // R4: 8-bit areas never strobe the lower lane
    p_upper_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.is8 && r_q.st != ST_IDLE) |-> ext_wr_lo_n);

    // R8: done lasts a single clock
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: read data register changes only together with done
    p_rdata_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rdata));

    // R10: selected area fixed while a transfer runs
    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE && r_q.st != ST_T1) |-> $stable(r_q.area));
endmodule

// File: tb/ext_bus_sizer_test.sv
`timescale 1ns/1ps
module ext_bus_sizer_test;

    localparam logic [7:0] CFG = 8'b1010_0101;

    typedef struct packed {
        logic [23:0] addr;
        logic [1:0]  size;
        logic        wr;
        logic [31:0] wdata;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{24'h000005, 2'd0, 1'b0, 32'h00000000},
        '{24'h000008, 2'd1, 1'b1, 32'h0000A1B2},
        '{24'h00000C, 2'd2, 1'b0, 32'h00000000},
        '{24'h400003, 2'd2, 1'b1, 32'h11223344},
        '{24'h200010, 2'd0, 1'b1, 32'h0000005A},
        '{24'h200011, 2'd0, 1'b0, 32'h00000000},
        '{24'h600006, 2'd1, 1'b0, 32'h00000000},
        '{24'h800020, 2'd2, 1'b1, 32'hDEADBEEF},
        '{24'hC00009, 2'd1, 1'b1, 32'h00007E81},
        '{24'hE0001C, 2'd2, 1'b0, 32'h00000000},
        '{24'h80002A, 2'd3, 1'b0, 32'h00000000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [23:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        done;
    logic [31:0] rdata;
    logic [23:0] ext_addr;
    logic [7:0]  ext_cs_n;
    logic        ext_rd_n, ext_wr_hi_n, ext_wr_lo_n;
    logic [15:0] ext_dout, ext_din;

    always #5 clk = ~clk;

    ext_bus_sizer uut (
        .clk(clk), .rst_n(rst_n), .area_is8(CFG),
        .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .done(done), .rdata(rdata),
        .ext_addr(ext_addr), .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n),
        .ext_wr_hi_n(ext_wr_hi_n), .ext_wr_lo_n(ext_wr_lo_n),
        .ext_dout(ext_dout), .ext_din(ext_din)
    );

    // external memory model, big-endian, 64 bytes
    logic [7:0]  mem [64];
    logic        cur_is8 = 1'b0;
    assign ext_din = cur_is8 ? {mem[ext_addr[5:0]], 8'hEE}
                             : {mem[{ext_addr[5:1], 1'b0}], mem[{ext_addr[5:1], 1'b1}]};

    int          checks = 0;
    int          errors = 0;
    int          ncyc = 0;
    int          cs_low = 0;
    int          lane_err = 0;
    logic [23:0] log_addr [8];
    logic [7:0]  log_cs [8];
    logic [7:0]  prev_cs = 8'hFF;

    function automatic logic [7:0] pat(input int i);
        return 8'(((i % 64) * 37) + 11);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic mem_init();
        for (int i = 0; i < 64; i++) mem[i] = pat(i);
    endtask

    task automatic log_clear();
        ncyc = 0; cs_low = 0; lane_err = 0;
    endtask

    // bus monitor and memory write port
    always @(negedge clk) begin
        if (rst_n) begin
            if (ext_cs_n != 8'hFF) begin
                cs_low++;
                if (prev_cs == 8'hFF) begin
                    if (ncyc < 8) begin
                        log_addr[ncyc] = ext_addr;
                        log_cs[ncyc]   = ext_cs_n;
                    end
                    ncyc++;
                    if (cur_is8) begin
                        if (!ext_wr_hi_n) mem[ext_addr[5:0]] = ext_dout[15:8];
                    end else begin
                        if (!ext_wr_hi_n) mem[{ext_addr[5:1], 1'b0}] = ext_dout[15:8];
                        if (!ext_wr_lo_n) mem[{ext_addr[5:1], 1'b1}] = ext_dout[7:0];
                    end
                end
            end
            if (cur_is8 && !ext_wr_lo_n) lane_err++;
        end
        prev_cs = ext_cs_n;
    end

    logic [31:0] last_read = '0;

    task automatic run_vec(input vec_t v);
        int          area, nb, nc, step, lat;
        logic [23:0] eff;
        logic [31:0] exp;
        string       tag;
        area = int'(v.addr[23:21]);
        cur_is8 = CFG[area];
        nb   = (v.size == 2'd0) ? 1 : (v.size == 2'd1) ? 2 : 4;
        eff  = (v.size != 2'd0) ? {v.addr[23:1], 1'b0} : v.addr;
        nc   = cur_is8 ? nb : ((v.size == 2'd0) ? 1 : nb / 2);
        step = cur_is8 ? 1 : 2;
        tag  = cur_is8 ? "R4" : "R6";
        mem_init();
        log_clear();
        @(negedge clk);
        req_valid = 1'b1; req_write = v.wr; req_size = v.size;
        req_addr = v.addr; req_wdata = v.wdata;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == 3 * nc + 1, "R8 done latency", 32'(lat), 32'(3 * nc + 1));
        chk(ncyc == nc, {tag, " cycle count"}, 32'(ncyc), 32'(nc));
        chk(cs_low == 2 * nc, "R3 chip-select low clocks", 32'(cs_low), 32'(2 * nc));
        chk(lane_err == 0, "R4 lower lane strobe in 8-bit area", 32'(lane_err), 32'd0);
        chk(log_addr[0] == eff, (v.addr[0] && v.size != 2'd0) ? "R9 first address" : {tag, " first address"},
            32'(log_addr[0]), 32'(eff));
        for (int k = 1; k < nc && k < 8; k++)
            chk(log_addr[k] == eff + 24'(k * step), {tag, " ascending address"},
                32'(log_addr[k]), 32'(eff + 24'(k * step)));
        for (int k = 0; k < nc && k < 8; k++)
            chk(log_cs[k] == ~(8'h01 << area), "R2 chip select", 32'(log_cs[k]), 32'(~(8'h01 << area)));
        if (!cur_is8 && v.size == 2'd0) tag = "R5";
        else tag = "R7";
        if (v.wr) begin
            for (int k = 0; k < nb; k++) begin
                logic [7:0] eb;
                eb = 8'(v.wdata >> ((nb - 1 - k) * 8));
                chk(mem[6'(eff + 24'(k))] == eb, {tag, " written byte"}, 32'(mem[6'(eff + 24'(k))]), 32'(eb));
            end
            if (!cur_is8 && v.size == 2'd0)
                chk(mem[6'(eff ^ 24'h1)] == pat(int'(eff[5:0] ^ 6'h1)), "R5 other lane untouched",
                    32'(mem[6'(eff ^ 24'h1)]), 32'(pat(int'(eff[5:0] ^ 6'h1))));
        end else begin
            exp = '0;
            for (int k = 0; k < nb; k++) exp = (exp << 8) | 32'(pat(int'(eff[5:0]) + k));
            chk(rdata == exp, {tag, " read result"}, rdata, exp);
            last_read = exp;
        end
    endtask

    initial begin
        mem_init();
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(ext_cs_n == 8'hFF, "R1 chip selects in reset", 32'(ext_cs_n), 32'hFF);
        chk({ext_rd_n, ext_wr_hi_n, ext_wr_lo_n} == 3'b111, "R1 strobes in reset",
            32'({ext_rd_n, ext_wr_hi_n, ext_wr_lo_n}), 32'h7);
        chk(done == 1'b0, "R1 done in reset", 32'(done), 32'h0);
        chk(rdata == 32'h0, "R1 rdata in reset", rdata, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(ext_cs_n == 8'hFF, "R1 idle after reset", 32'(ext_cs_n), 32'hFF);

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R8: a write leaves rdata at the last read result
        run_vec(VEC[1]);
        repeat (3) @(negedge clk);
        chk(rdata == last_read, "R8 rdata held across write", rdata, last_read);

        // R10: request raised during a transfer is dropped
        mem_init();
        log_clear();
        cur_is8 = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_size = 2'd1; req_addr = 24'h200000;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = 24'hA00004; req_size = 2'd0;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk(done == 1'b1, "R10 done of first request", 32'(done), 32'h1);
        chk(rdata == {16'h0, pat(0), pat(1)}, "R10 first request data", rdata, {16'h0, pat(0), pat(1)});
        repeat (6) @(negedge clk);
        chk(ncyc == 1, "R10 no extra cycle", 32'(ncyc), 32'd1);
        chk(log_cs[0] == 8'hFD, "R10 only first area selected", 32'(log_cs[0]), 32'hFD);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule